// File: doc/BRIEF.md
# Daisy-Chainable Channel Programming Serial Slave

This block is the programming front end of a multi-channel reference generator. A host drives three wires: an active-low frame enable, a serial clock and a serial data line. While the enable is low, each rising serial clock edge moves one data bit into a 16-bit shift register, most significant bit first. When the enable returns high, the word in the shift register is checked and, if it is well formed, its 10-bit value is written into one of 18 channel registers. All 18 registers leave the block side by side, as a flat parallel bus, for a downstream refresh engine.

The shift register's top bit is sent out on a serial output on falling serial clock edges. Several devices can therefore be cascaded, each output feeding the next device's data input, with all of them sharing the enable and the serial clock. The host shifts one word per device, and the word shifted first ends up in the device furthest down the chain. The enable and the serial clock are asynchronous to the system clock. They are synchronized and edge-detected inside the block, so the serial clock must run well below the system clock.

Top module: `chan_prog_spi`

## Requirements
- R1: While the enable input is high, serial clock edges are ignored. The shift register keeps its content, the serial output holds, and no channel changes.
- R2: While the enable input is low, data is sampled on each rising serial clock edge into a 16-bit shift register. New bits enter at bit 0, so the first bit sent ends up in bit 15.
- R3: The word layout is: bit 15 is a test bit that must be 0, bits 14..10 are the channel address (0 to 17), and bits 9..0 are the value. When the enable rises on a valid word, the addressed channel is loaded and no other channel changes. Channel i appears on `chan_val_o[i*10 +: 10]`.
- R4: A word whose bit 15 is 1 is discarded at commit.
- R5: A word whose address is greater than 17 is discarded at commit.
- R6: A frame with fewer than 16 rising serial clock edges is discarded at commit.
- R7: A frame with more than 16 rising serial clock edges commits only the last 16 bits received.
- R8: On each falling serial clock edge while the enable is low, the serial output takes bit 15 of the shift register. As a result, a bit applied at the data input appears at the output on the 16th falling edge after it was sampled. At all other times the serial output holds its value.
- R9: Reset clears all 18 channel registers, the shift register and the serial output to 0.
- R10: In two cascaded devices sharing the enable and the serial clock, a 32-bit frame leaves the first word in the downstream device and the second word in the upstream device. Both devices commit on the same rising edge of the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Frame enable, active low (asynchronous) |
| sck_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output for cascading |
| chan_val_o | output | 180 | Channel values, channel i at bits i*10+9..i*10 |

## Verification
A pin change passes two synchronizer flops and an edge detector, and then takes effect at the following clock edge. A shift or a serial output update is therefore visible three system clock edges after the serial clock edge, and a channel write three edges after the enable rises. The bench holds each serial clock phase for six system clock cycles. It samples the serial output at the end of the low phase after each falling edge, which is after the update and before the next rising edge. It compares channel registers twelve cycles after the enable rises. A serial clock edge and an enable edge are never issued within the same six-cycle window.

// File: rtl/cps_pkg.sv
package cps_pkg;

    localparam int unsigned CPS_NUM_CH = 18;
    localparam int unsigned CPS_VAL_W  = 10;
    localparam int unsigned CPS_ADDR_W = 5;
    localparam int unsigned CPS_SYNC   = 2;

    // outcome of checking a received word at frame end
    typedef enum logic [1:0] {
        VERDICT_OK    = 2'd0,
        VERDICT_SHORT = 2'd1,
        VERDICT_TEST  = 2'd2,
        VERDICT_RANGE = 2'd3
    } verdict_e;

endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = raw_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pipe <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.pipe[STAGES-1];

endmodule

// File: rtl/cps_edge.sv
module cps_edge #(
    parameter int unsigned W = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = lvl_i & ~st_q.prev;
    assign fall_o = ~lvl_i & st_q.prev;

endmodule

// File: rtl/cps_shift_engine.sv
module cps_shift_engine #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lvl_i,
    input  logic              sel_fall_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              sdi_lvl_i,
    output logic [WORD_W-1:0] word_o,
    output logic              full_o,
    output logic              sdo_o
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              sdo;
    } shift_st_t;

    shift_st_t        st_d, st_q;
    logic [CNT_W-1:0] cnt_base;
    logic             active;

    always_comb begin
        st_d     = st_q;
        active   = ~sel_lvl_i;
        cnt_base = sel_fall_i ? '0 : st_q.cnt;
        st_d.cnt = cnt_base;
        if (active && sck_rise_i) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], sdi_lvl_i};
            if (cnt_base != CNT_FULL) begin
                st_d.cnt = cnt_base + 1'b1;
            end
        end
        if (active && sck_fall_i) begin
            st_d.sdo = st_q.sr[WORD_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr  <= '0;
            st_q.cnt <= '0;
            st_q.sdo <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.sr;
    assign full_o = (st_q.cnt == CNT_FULL);
    assign sdo_o  = st_q.sdo;

endmodule

// File: rtl/cps_chan_file.sv
module cps_chan_file
    import cps_pkg::*;
#(
    parameter int unsigned NUM_CH = CPS_NUM_CH,
    parameter int unsigned VAL_W  = CPS_VAL_W,
    parameter int unsigned ADDR_W = CPS_ADDR_W,
    localparam int unsigned WORD_W = 1 + ADDR_W + VAL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit_i,
    input  logic [WORD_W-1:0]        word_i,
    input  logic                     full_i,
    output logic [NUM_CH*VAL_W-1:0]  vals_o
);

    localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'(NUM_CH - 1);

    typedef struct packed {
        logic [NUM_CH-1:0][VAL_W-1:0] vals;
    } file_st_t;

    file_st_t          st_d, st_q;
    logic              test_bit;
    logic [ADDR_W-1:0] addr;
    logic [VAL_W-1:0]  data;
    verdict_e          verdict;

    assign test_bit = word_i[WORD_W-1];
    assign addr     = word_i[WORD_W-2 -: ADDR_W];
    assign data     = word_i[VAL_W-1:0];

    // priority: length first, then test bit, then address range
    always_comb begin
        if (!full_i) begin
            verdict = VERDICT_SHORT;
        end else if (test_bit) begin
            verdict = VERDICT_TEST;
        end else if (addr > LAST_CH) begin
            verdict = VERDICT_RANGE;
        end else begin
            verdict = VERDICT_OK;
        end
    end

    always_comb begin
        st_d = st_q;
        if (commit_i && (verdict == VERDICT_OK)) begin
            for (int i = 0; i < int'(NUM_CH); i++) begin
                if (addr == ADDR_W'(i)) begin
                    st_d.vals[i] = data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vals <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_flat
        assign vals_o[g*VAL_W +: VAL_W] = st_q.vals[g];
    end

endmodule

// File: rtl/chan_prog_spi.sv
module chan_prog_spi
    import cps_pkg::*;
#(
    parameter int unsigned NUM_CH = CPS_NUM_CH,
    parameter int unsigned VAL_W  = CPS_VAL_W,
    parameter int unsigned ADDR_W = CPS_ADDR_W,
    parameter int unsigned SYNC   = CPS_SYNC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n_i,
    input  logic                    sck_i,
    input  logic                    sdi_i,
    output logic                    sdo_o,
    output logic [NUM_CH*VAL_W-1:0] chan_val_o
);

    localparam int unsigned WORD_W = 1 + ADDR_W + VAL_W;

    // bit 0 enable, bit 1 serial clock, bit 2 data
    logic [2:0]        pin_lvl;
    logic [1:0]        pin_rise;
    logic [1:0]        pin_fall;
    logic              sel_lvl, sel_rise, sel_fall;
    logic              sck_rise, sck_fall, sdi_lvl;
    logic [WORD_W-1:0] sh_word;
    logic              sh_full;

    cps_sync #(
        .W       (3),
        .STAGES  (SYNC),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sdi_i, sck_i, sel_n_i}),
        .lvl_o (pin_lvl)
    );

    cps_edge #(
        .W       (2),
        .RST_VAL (2'b01)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_lvl[1:0]),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign sel_lvl  = pin_lvl[0];
    assign sel_rise = pin_rise[0];
    assign sel_fall = pin_fall[0];
    assign sck_rise = pin_rise[1];
    assign sck_fall = pin_fall[1];
    assign sdi_lvl  = pin_lvl[2];

    cps_shift_engine #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_lvl_i  (sel_lvl),
        .sel_fall_i (sel_fall),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .sdi_lvl_i  (sdi_lvl),
        .word_o     (sh_word),
        .full_o     (sh_full),
        .sdo_o      (sdo_o)
    );

    cps_chan_file #(
        .NUM_CH (NUM_CH),
        .VAL_W  (VAL_W),
        .ADDR_W (ADDR_W)
    ) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (sel_rise),
        .word_i   (sh_word),
        .full_i   (sh_full),
        .vals_o   (chan_val_o)
    );

endmodule

// File: rtl/cps_chk.sv
module cps_chk #(
    parameter int unsigned NUM_CH = 18,
    parameter int unsigned VAL_W  = 10,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned WORD_W = 1 + ADDR_W + VAL_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sel_lvl,
    input logic                    sel_rise,
    input logic                    sck_rise,
    input logic                    sck_fall,
    input logic                    sdi_lvl,
    input logic [WORD_W-1:0]       sh_word,
    input logic                    sh_full,
    input logic                    sdo_o,
    input logic [NUM_CH*VAL_W-1:0] chan_val_o
);

    localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'(NUM_CH - 1);

    logic [ADDR_W-1:0] w_addr;
    assign w_addr = sh_word[WORD_W-2 -: ADDR_W];

    AST_IDLE_HOLDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lvl |=> $stable(sh_word)); // R1

    AST_MSB_FIRST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lvl && sck_rise) |=> (sh_word == {$past(sh_word[WORD_W-2:0]), $past(sdi_lvl)})); // R2

    AST_NO_WRITE_OUTSIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_rise |=> $stable(chan_val_o)); // R3

    AST_REJECT_TEST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rise && sh_word[WORD_W-1]) |=> $stable(chan_val_o)); // R4

    AST_REJECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rise && (w_addr > LAST_CH)) |=> $stable(chan_val_o)); // R5

    AST_REJECT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rise && !sh_full) |=> $stable(chan_val_o)); // R6

    AST_SDO_FROM_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lvl && sck_fall) |=> (sdo_o == $past(sh_word[WORD_W-1]))); // R8

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sel_lvl && sck_fall) |=> $stable(sdo_o)); // R8

endmodule

bind chan_prog_spi cps_chk #(
    .NUM_CH (NUM_CH),
    .VAL_W  (VAL_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_lvl    (sel_lvl),
    .sel_rise   (sel_rise),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .sdi_lvl    (sdi_lvl),
    .sh_word    (sh_word),
    .sh_full    (sh_full),
    .sdo_o      (sdo_o),
    .chan_val_o (chan_val_o)
);

// File: tb/chan_prog_spi_tb.sv
`timescale 1ns/1ps
module chan_prog_spi_tb;

    localparam int NCH = 18;
    localparam int VW  = 10;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo1, sdo2;
    logic [NCH*VW-1:0] vals1, vals2;

    int n_chk = 0;
    int n_bad = 0;
    logic [VW-1:0] exp1 [NCH];
    logic [VW-1:0] exp2 [NCH];
    logic sdo_log [65];

    always #2.5 clk = ~clk;

    chan_prog_spi u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck),
        .sdi_i(sdi), .sdo_o(sdo1), .chan_val_o(vals1)
    );

    // downstream device in the cascade
    chan_prog_spi u_dut2 (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck),
        .sdi_i(sdo1), .sdo_o(sdo2), .chan_val_o(vals2)
    );

    // {expect_write, word}
    localparam logic [16:0] VEC [9] = '{
        {1'b1, 16'h0000},
        {1'b1, 16'h03FF},
        {1'b1, 16'h0C01},
        {1'b1, 16'h4555},
        {1'b1, 16'h16AA},
        {1'b0, 16'h8805},
        {1'b0, 16'h4807},
        {1'b0, 16'h7FFF},
        {1'b1, 16'h2600}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NCH; i++) begin
            check(req, {22'b0, vals1[i*VW +: VW]}, {22'b0, exp1[i]});
        end
    endtask

    task automatic check_all2(input string req);
        for (int i = 0; i < NCH; i++) begin
            check(req, {22'b0, vals2[i*VW +: VW]}, {22'b0, exp2[i]});
        end
    endtask

    // one frame of n bits, first bit is bits[n-1]; sdo_log[k] = output after fall k
    task automatic frame(input logic [63:0] bits, input int n);
        sck = 1'b0;
        sel_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < n; k++) begin
            sdi = bits[n-1-k];
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
            wait_clk(HALF);
            sdo_log[k+1] = sdo1;
        end
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(12);
    endtask

    function automatic string tag_of(input logic [15:0] w);
        if (w[15]) return "R4";
        if (w[14:10] > 5'd17) return "R5";
        return "R3";
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        sel_n = 1'b1;
        sck = 1'b0;
        sdi = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        for (int i = 0; i < NCH; i++) begin
            exp1[i] = '0;
            exp2[i] = '0;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic sdo_before;

        do_reset();
        // R9: reset state
        check_all("R9");
        check("R9", {31'b0, sdo1}, 32'd0);

        // R3 R4 R5: table walk
        for (int v = 0; v < 9; v++) begin
            w = VEC[v][15:0];
            frame({48'b0, w}, 16);
            if (VEC[v][16]) exp1[w[14:10]] = w[9:0];
            check_all(tag_of(w));
        end

        // R6: only 10 bits of a valid word for channel 1
        frame({54'b0, 10'h003}, 10);
        check_all("R6");

        // R7: 20 bits, last 16 = channel 4 value 0x077
        frame({44'b0, 4'hF, 16'h1077}, 20);
        exp1[4] = 10'h077;
        check_all("R7");

        // R1: toggle the serial clock with data 1 while enable is high
        sdo_before = sdo1;
        for (int k = 0; k < 16; k++) begin
            sdi = 1'b1;
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        check("R1", {31'b0, sdo1}, {31'b0, sdo_before});
        check_all("R1");
        // new frame: first output bit is bit 14 of the untouched 0x1077 (0)
        frame({48'b0, 16'h1C0F}, 16);
        check("R1", {31'b0, sdo_log[1]}, 32'd0);
        exp1[7] = 10'h00F;
        check_all("R3");

        // R9: reset in the middle of operation
        do_reset();
        check_all("R9");
        check_all2("R9");
        check("R9", {31'b0, sdo1}, 32'd0);

        // R10 R8 R7: cascade, first word 0x0555 (ch1) then 0x0AAA (ch2)
        frame({32'b0, 16'h0555, 16'h0AAA}, 32);
        for (int m = 16; m < 32; m++) begin
            check("R8", {31'b0, sdo_log[m]}, {31'b0, 1'(16'h0555 >> (31 - m))});
        end
        exp1[2] = 10'h2AA;
        exp2[1] = 10'h155;
        check_all("R10");
        check_all2("R10");

        summary();
        $finish;
    end

endmodule